// File: doc/BRIEF.md
# Privilege Mode Controller

This block holds the execution mode of a small processor core: a fully privileged supervisor mode for operating-system code and a restricted user mode for applications. Each cycle it takes single-cycle flags from the instruction decoder and a service request from outside devices. From these it decides the next mode, whether the current instruction must be rejected as illegal, and whether the fetch unit must be redirected to a fixed handler address.

The mode can change in three ways. Supervisor code can store to the mode register, which acts as a control port and not as storage. A system-call instruction raises privilege as a side effect. A device request forces supervisor mode in hardware and redirects fetch to the device handler.

When supervisor mode is entered through a system call or a device request, a one-bit shadow register records the mode that was left. A return instruction restores that mode. In user mode, three operations are rejected and trap: a privileged operation, a mode-register store and a return. The mode is left as it was.

The mode register is a two-state machine with the states SUPER and USER. The transitions are:
- USER→SUPER on a system call or a device request.
- SUPER→USER on a return when the shadow holds user, or on a store of 0.
- SUPER→SUPER on a system call, a device request, a return when the shadow holds supervisor, or a store of 1.
- USER→USER on an illegal operation.

One event is chosen per cycle. The order, from first to last, is: device, system call, illegal operation, return, mode store.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 1 (1 = supervisor, 0 = user), and trap_o and vec_valid_o are 0.
- R2: In supervisor mode, a mode store (mode_wr_i) sets mode_o to mode_wr_data_i on the next cycle, with no trap and no vector.
- R3: In user mode, priv_op_i makes trap_o and vec_valid_o 1 on the next cycle, with vec_addr_o = VEC_TRAP (default 0x100), and mode_o stays 0.
- R4: In user mode, a mode store or a return (ret_i) is also illegal: trap_o is 1 and mode_o stays 0 whatever the store data.
- R5: In supervisor mode, priv_op_i has no effect: trap_o is 0, vec_valid_o is 0 and mode_o stays 1.
- R6: syscall_i sets mode_o to 1 and raises vec_valid_o with vec_addr_o = VEC_SYS (default 0x200), with no trap.
- R7: dev_req_i sets mode_o to 1 and raises vec_valid_o with vec_addr_o = VEC_DEV (default 0x300).
- R8: A device request in the same cycle as a system call or an illegal operation wins: only VEC_DEV is issued, and trap_o is 0.
- R9: Entering supervisor mode through a system call or a device request saves the previous mode in a one-bit shadow register. A return in supervisor mode sets mode_o to the shadow value.
- R10: In supervisor mode, a return and a mode store in the same cycle are resolved in favour of the return.
- R11: In user mode, a system call in the same cycle as a privileged operation wins: VEC_SYS is issued and trap_o is 0.
- R12: trap_o and vec_valid_o are one-cycle pulses. They are 0 in the cycle after an event when no new event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_op_i | input | 1 | Decoded privileged operation |
| syscall_i | input | 1 | Decoded system-call instruction |
| mode_wr_i | input | 1 | Store to the mode register |
| mode_wr_data_i | input | 1 | Mode value to store (1 = supervisor) |
| ret_i | input | 1 | Return-to-previous-mode instruction |
| dev_req_i | input | 1 | Device service request |
| mode_o | output | 1 | Current mode (1 = supervisor) |
| trap_o | output | 1 | Illegal-instruction trap pulse |
| vec_valid_o | output | 1 | Fetch redirect request |
| vec_addr_o | output | ADDR_W | Redirect target address |

## Verification
Every result of this block is due at the first rising edge after the cycle in which its flags are held. This covers the mode change, the trap pulse and the vector request with its address. The pulses drop again one edge later. The bench changes its inputs at a falling edge, holds them through exactly one rising edge, and reads the outputs at the next falling edge. Each check therefore sees the result of exactly one event. A second idle sample confirms that the pulses are one cycle wide. The order of scenarios steers the shadow register through both of its values, so that a return is checked for both outcomes.

// File: rtl/priv_mode_pkg.sv
package priv_mode_pkg;

    typedef enum logic {
        MODE_USER  = 1'b0,
        MODE_SUPER = 1'b1
    } pmode_e;

    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_DEVICE  = 3'd1,
        EV_SYSCALL = 3'd2,
        EV_ILLEGAL = 3'd3,
        EV_RETURN  = 3'd4,
        EV_WRITE   = 3'd5
    } pevent_e;

endpackage

// File: rtl/priv_event_arb.sv
module priv_event_arb
    import priv_mode_pkg::*;
(
    input  pmode_e  cur_mode,
    input  logic    priv_op,
    input  logic    syscall,
    input  logic    mode_wr,
    input  logic    ret,
    input  logic    dev_req,
    output pevent_e ev
);

    logic user_mode;
    logic illegal;

    always_comb begin
        user_mode = (cur_mode == MODE_USER);
        illegal   = user_mode && (priv_op || mode_wr || ret);
    end

    // Fixed priority: device, system call, illegal, return, store.
    always_comb begin
        if (dev_req) begin
            ev = EV_DEVICE;
        end else if (syscall) begin
            ev = EV_SYSCALL;
        end else if (illegal) begin
            ev = EV_ILLEGAL;
        end else if (ret) begin
            ev = EV_RETURN;
        end else if (mode_wr) begin
            ev = EV_WRITE;
        end else begin
            ev = EV_NONE;
        end
    end

endmodule

// File: rtl/priv_vector_gen.sv
module priv_vector_gen
    import priv_mode_pkg::*;
#(
    parameter int                 ADDR_W   = 32,
    parameter logic [ADDR_W-1:0]  VEC_TRAP = 'h100,
    parameter logic [ADDR_W-1:0]  VEC_SYS  = 'h200,
    parameter logic [ADDR_W-1:0]  VEC_DEV  = 'h300
)(
    input  logic              clk,
    input  logic              rst_n,
    input  pevent_e           ev,
    output logic              trap_o,
    output logic              vec_valid_o,
    output logic [ADDR_W-1:0] vec_addr_o
);

    logic              trap_d;
    logic              valid_d;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        trap_d  = 1'b0;
        valid_d = 1'b0;
        addr_d  = '0;
        unique case (ev)
            EV_DEVICE: begin
                valid_d = 1'b1;
                addr_d  = VEC_DEV;
            end
            EV_SYSCALL: begin
                valid_d = 1'b1;
                addr_d  = VEC_SYS;
            end
            EV_ILLEGAL: begin
                trap_d  = 1'b1;
                valid_d = 1'b1;
                addr_d  = VEC_TRAP;
            end
            EV_NONE, EV_RETURN, EV_WRITE: begin
                valid_d = 1'b0;
            end
            default: begin
                valid_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_o      <= 1'b0;
            vec_valid_o <= 1'b0;
            vec_addr_o  <= '0;
        end else begin
            trap_o      <= trap_d;
            vec_valid_o <= valid_d;
            vec_addr_o  <= addr_d;
        end
    end

    // R3
    trap_goes_to_trap_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (vec_valid_o && vec_addr_o == VEC_TRAP));

    // R12
    trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && $past(ev) != EV_ILLEGAL) |-> 1'b0);

endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
    import priv_mode_pkg::*;
#(
    parameter int                 ADDR_W   = 32,
    parameter logic [ADDR_W-1:0]  VEC_TRAP = 'h100,
    parameter logic [ADDR_W-1:0]  VEC_SYS  = 'h200,
    parameter logic [ADDR_W-1:0]  VEC_DEV  = 'h300
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv_op_i,
    input  logic              syscall_i,
    input  logic              mode_wr_i,
    input  logic              mode_wr_data_i,
    input  logic              ret_i,
    input  logic              dev_req_i,
    output logic              mode_o,
    output logic              trap_o,
    output logic              vec_valid_o,
    output logic [ADDR_W-1:0] vec_addr_o
);

    pmode_e  state_q, state_d;
    pmode_e  shadow_q, shadow_d;
    pevent_e ev;

    priv_event_arb u_arb (
        .cur_mode (state_q),
        .priv_op  (priv_op_i),
        .syscall  (syscall_i),
        .mode_wr  (mode_wr_i),
        .ret      (ret_i),
        .dev_req  (dev_req_i),
        .ev       (ev)
    );

    priv_vector_gen #(
        .ADDR_W   (ADDR_W),
        .VEC_TRAP (VEC_TRAP),
        .VEC_SYS  (VEC_SYS),
        .VEC_DEV  (VEC_DEV)
    ) u_vec (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .trap_o      (trap_o),
        .vec_valid_o (vec_valid_o),
        .vec_addr_o  (vec_addr_o)
    );

    // Next-state logic for the mode machine and its shadow bit.
    always_comb begin
        state_d  = state_q;
        shadow_d = shadow_q;
        unique case (state_q)
            MODE_SUPER: begin
                unique case (ev)
                    EV_DEVICE, EV_SYSCALL: begin
                        shadow_d = MODE_SUPER;
                    end
                    EV_RETURN: begin
                        state_d = shadow_q;
                    end
                    EV_WRITE: begin
                        state_d = mode_wr_data_i ? MODE_SUPER : MODE_USER;
                    end
                    EV_NONE, EV_ILLEGAL: begin
                        state_d = MODE_SUPER;
                    end
                    default: begin
                        state_d = MODE_SUPER;
                    end
                endcase
            end
            MODE_USER: begin
                unique case (ev)
                    EV_DEVICE, EV_SYSCALL: begin
                        state_d  = MODE_SUPER;
                        shadow_d = MODE_USER;
                    end
                    EV_NONE, EV_ILLEGAL, EV_RETURN, EV_WRITE: begin
                        state_d = MODE_USER;
                    end
                    default: begin
                        state_d = MODE_USER;
                    end
                endcase
            end
            default: begin
                state_d = MODE_SUPER;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= MODE_SUPER;
            shadow_q <= MODE_SUPER;
        end else begin
            state_q  <= state_d;
            shadow_q <= shadow_d;
        end
    end

    // Outputs.
    always_comb begin
        mode_o = (state_q == MODE_SUPER);
    end

    // R4
    trap_keeps_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (!mode_o && !$past(mode_o)));

    // R2
    drop_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_o && $past(mode_o)) |-> $past(mode_wr_i || ret_i));

    // R7
    dev_vec_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && vec_addr_o == VEC_DEV) |-> mode_o);

    // R6
    sys_vec_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && vec_addr_o == VEC_SYS) |-> mode_o);

    // R5
    super_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_o) |-> !trap_o);

endmodule

// File: tb/sim_priv_mode_ctrl.sv
module sim_priv_mode_ctrl;

    localparam int ADDR_W = 32;
    localparam logic [ADDR_W-1:0] A_TRAP = 32'h100;
    localparam logic [ADDR_W-1:0] A_SYS  = 32'h200;
    localparam logic [ADDR_W-1:0] A_DEV  = 32'h300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic priv_op = 1'b0, syscall = 1'b0, mode_wr = 1'b0;
    logic wr_data = 1'b0, ret = 1'b0, dev_req = 1'b0;
    logic mode, trap, vv;
    logic [ADDR_W-1:0] vaddr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    priv_mode_ctrl u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .priv_op_i      (priv_op),
        .syscall_i      (syscall),
        .mode_wr_i      (mode_wr),
        .mode_wr_data_i (wr_data),
        .ret_i          (ret),
        .dev_req_i      (dev_req),
        .mode_o         (mode),
        .trap_o         (trap),
        .vec_valid_o    (vv),
        .vec_addr_o     (vaddr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Hold flags through one rising edge, read results at the next falling edge.
    task automatic step(input logic d, input logic s, input logic p,
                        input logic w, input logic wd, input logic r);
        dev_req = d; syscall = s; priv_op = p;
        mode_wr = w; wr_data = wd; ret = r;
        @(negedge clk);
        dev_req = 0; syscall = 0; priv_op = 0;
        mode_wr = 0; wr_data = 0; ret = 0;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        check("R1", "mode", mode, 1);
        check("R1", "trap", trap, 0);
        check("R1", "vec_valid", vv, 0);
    endtask

    task automatic t_priv_super();
        step(0, 0, 1, 0, 0, 0);
        check("R5", "trap", trap, 0);
        check("R5", "vec_valid", vv, 0);
        check("R5", "mode", mode, 1);
    endtask

    task automatic t_write_super();
        step(0, 0, 0, 1, 0, 0);
        check("R2", "mode", mode, 0);
        check("R2", "vec_valid", vv, 0);
        check("R2", "trap", trap, 0);
    endtask

    task automatic t_priv_user();
        step(0, 0, 1, 0, 0, 0);
        check("R3", "trap", trap, 1);
        check("R3", "vec_valid", vv, 1);
        check("R3", "vec_addr", vaddr, A_TRAP);
        check("R3", "mode", mode, 0);
        idle();
        check("R12", "trap", trap, 0);
        check("R12", "vec_valid", vv, 0);
    endtask

    task automatic t_illegal_user();
        step(0, 0, 0, 1, 1, 0);
        check("R4", "trap on store", trap, 1);
        check("R4", "mode after store", mode, 0);
        step(0, 0, 0, 0, 0, 1);
        check("R4", "trap on return", trap, 1);
        check("R4", "mode after return", mode, 0);
    endtask

    task automatic t_syscall_user();
        step(0, 1, 0, 0, 0, 0);
        check("R6", "mode", mode, 1);
        check("R6", "vec_valid", vv, 1);
        check("R6", "vec_addr", vaddr, A_SYS);
        check("R6", "trap", trap, 0);
    endtask

    task automatic t_return_user();
        step(0, 0, 0, 0, 0, 1);
        check("R9", "mode restored to user", mode, 0);
        check("R9", "vec_valid", vv, 0);
    endtask

    task automatic t_device_nested();
        step(1, 0, 0, 0, 0, 0);
        check("R7", "mode", mode, 1);
        check("R7", "vec_valid", vv, 1);
        check("R7", "vec_addr", vaddr, A_DEV);
        idle();
        check("R12", "vec_valid after device", vv, 0);
        step(0, 1, 0, 0, 0, 0);
        check("R6", "syscall in super mode", mode, 1);
        step(0, 0, 0, 0, 0, 1);
        check("R9", "return to saved super", mode, 1);
        step(0, 0, 0, 0, 0, 1);
        check("R9", "second return keeps super", mode, 1);
        step(0, 0, 0, 1, 0, 0);
        check("R2", "store user", mode, 0);
    endtask

    task automatic t_device_priority();
        step(1, 1, 1, 0, 0, 0);
        check("R8", "vec_addr", vaddr, A_DEV);
        check("R8", "trap", trap, 0);
        check("R8", "mode", mode, 1);
        step(0, 0, 0, 0, 0, 1);
        check("R9", "return after device", mode, 0);
    endtask

    task automatic t_syscall_priority();
        step(0, 1, 1, 0, 0, 0);
        check("R11", "vec_addr", vaddr, A_SYS);
        check("R11", "trap", trap, 0);
        check("R11", "mode", mode, 1);
    endtask

    task automatic t_ret_and_write();
        step(0, 0, 0, 1, 1, 1);
        check("R10", "mode", mode, 0);
        check("R10", "vec_valid", vv, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priv_super();
        t_write_super();
        t_priv_user();
        t_illegal_user();
        t_syscall_user();
        t_return_user();
        t_device_nested();
        t_device_priority();
        t_syscall_priority();
        t_ret_and_write();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule